// File: doc/BRIEF.md
# Multiplexed Bus Phase Demultiplexer

This block watches a four-phase processor bus on which one address bus and one data bus carry two unrelated transfers in each machine cycle. The bus is paced by two clocks whose levels, taken together, name the current phase. The second clock arrives inverted. The block samples every bus line through a two-flop synchroniser in a faster system clock. It restores the second clock, decodes the phase from the two levels and follows the phase order. It then rebuilds two kinds of record from the bus.

The first kind is a fetch record. It joins the program-store address seen in the first active phase with the instruction byte seen in the second active phase of the same cycle. The second kind is an access record. It joins the read/IO address seen in the second active phase with the data byte that shows up in the first active phase of the *following* cycle, because that data belongs to the earlier access.

Records are only reported inside a capture window. The window is armed when the watched processor's reset line goes inactive. It then skips a programmable number of machine cycles, reports a programmable number of fetch records, and closes. The next release of the processor reset arms it again.

Top module: `pbus_phase_demux`

## Requirements
- R1: The phase is decoded from the clock A level and the restored clock B level (the inverse of `bus_clkb_n`). The pairs {A,B} = 10, 11, 01 and 00 are the fetch-address phase, the first clear phase, the access-address phase and the second clear phase, and they must follow in that order.
- R2: A fetch record carries the address sampled in the fetch-address phase and the data sampled in the access-address phase of the same cycle. It is reported by a single-cycle `fetch_valid` pulse after that access-address phase ends.
- R3: An access record carries the address sampled in the access-address phase of one cycle and the data sampled in the fetch-address phase of the next cycle. It is reported by a single-cycle `io_valid` pulse after that fetch-address phase ends.
- R4: After system reset, and after any phase step that breaks the order of R1, no record is reported until the bus enters the second clear phase. An access record also needs an access address latched since that point.
- R5: After `tgt_rst_n` rises, the fetch records of the first `pretrig_cycles` machine cycles are not reported. A value of 0 opens the window at once.
- R6: After `capture_len` fetch records (1 or more) have been reported, the window closes and no further records of either kind are reported.
- R7: While `tgt_rst_n` is low the window is closed and no records are reported. Each new release re-arms the window.
- R8: `fetch_valid` and `io_valid` are never high in the same cycle, and no record is reported while the window is closed.
- R9: After system reset, `fetch_valid`, `io_valid` and `window_open` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, faster than the bus phases |
| rst_n | input | 1 | Active-low system reset |
| tgt_rst_n | input | 1 | Watched processor reset, active low; its release arms the window |
| bus_clka | input | 1 | Bus clock A level |
| bus_clkb_n | input | 1 | Bus clock B level, arriving inverted |
| bus_addr | input | AW (12) | Multiplexed address bus |
| bus_data | input | DW (8) | Multiplexed data bus |
| pretrig_cycles | input | PRE_W (16) | Machine cycles to skip after release |
| capture_len | input | LEN_W (16) | Fetch records to report per window |
| fetch_valid | output | 1 | One-cycle strobe for a fetch record |
| fetch_addr | output | AW | Program-store address of the record |
| fetch_data | output | DW | Instruction byte of the record |
| io_valid | output | 1 | One-cycle strobe for an access record |
| io_addr | output | AW | Read/IO address of the record |
| io_data | output | DW | Data byte that belongs to that address |
| window_open | output | 1 | High while the capture window accepts records |

## Verification
The bound checker covers, on every cycle, the properties that can be stated over the ports. Both strobes are single-cycle pulses and never coincide. No record appears outside a window. A held processor reset keeps the window shut. The number of fetch records in a window never exceeds `capture_len`.

Whether each record pairs the right address with the right byte cannot be shown by these properties. The cross-cycle pairing of access data is in the same position, and so are the exact number of skipped cycles, the loss and recovery of phase lock after a broken phase order, and re-arming on a second release. Only the bench's scenarios show these, by comparing against a behavioural model of the bus cycles.

// File: rtl/pbd_pkg.sv
package pbd_pkg;

    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_CLR1  = 2'd1,
        PH_ACC   = 2'd2,
        PH_CLR2  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        WIN_IDLE = 2'd0,
        WIN_PRE  = 2'd1,
        WIN_OPEN = 2'd2,
        WIN_DONE = 2'd3
    } win_e;

    // {A, restored B}: 10 fetch, 11 clear, 01 access, 00 clear
    function automatic phase_e phase_of(input logic a, input logic b);
        case ({a, b})
            2'b10:   return PH_FETCH;
            2'b11:   return PH_CLR1;
            2'b01:   return PH_ACC;
            default: return PH_CLR2;
        endcase
    endfunction

    function automatic phase_e phase_next(input phase_e p);
        return phase_e'(p + 2'd1);
    endfunction

endpackage

// File: rtl/pbd_sync.sv
module pbd_sync #(
    parameter int          W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.s1 = d;
        r_d.s2 = r_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.s1 <= RST_VAL;
            r_q.s2 <= RST_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign q = r_q.s2;
endmodule

// File: rtl/pbd_phase_track.sv
module pbd_phase_track
    import pbd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   lvl_a,
    input  logic   lvl_b_n,
    output phase_e ph_now,
    output logic   exit_fetch,
    output logic   exit_acc,
    output logic   lock_lost
);
    typedef struct packed {
        phase_e ph;
        logic   lock;
    } trk_t;

    trk_t r_d, r_q;
    logic step, legal;

    always_comb begin
        ph_now     = phase_of(lvl_a, ~lvl_b_n);
        step       = (ph_now != r_q.ph);
        legal      = (ph_now == phase_next(r_q.ph));
        exit_fetch = r_q.lock && step && legal && (r_q.ph == PH_FETCH);
        exit_acc   = r_q.lock && step && legal && (r_q.ph == PH_ACC);
        lock_lost  = step && !legal;

        r_d    = r_q;
        r_d.ph = ph_now;
        if (lock_lost) begin
            r_d.lock = 1'b0;
        end else if (step && ph_now == PH_CLR2) begin
            r_d.lock = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ph   <= PH_CLR2;
            r_q.lock <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/pbd_window.sv
module pbd_window
    import pbd_pkg::*;
#(
    parameter int PRE_W = 16,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tgt_run,
    input  logic             cycle_end,
    input  logic [PRE_W-1:0] pretrig,
    input  logic [LEN_W-1:0] cap_len,
    output logic             is_open
);
    localparam int CNT_W = (PRE_W > LEN_W) ? PRE_W : LEN_W;

    typedef struct packed {
        win_e             st;
        logic             run_prev;
        logic [CNT_W-1:0] cnt;
    } win_t;

    win_t r_d, r_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        r_d          = r_q;
        r_d.run_prev = tgt_run;
        cnt_inc      = r_q.cnt + CNT_W'(1);
        if (!tgt_run) begin
            r_d.st  = WIN_IDLE;
            r_d.cnt = '0;
        end else if (!r_q.run_prev) begin
            r_d.st  = (pretrig == '0) ? WIN_OPEN : WIN_PRE;
            r_d.cnt = CNT_W'(pretrig);
            if (pretrig == '0) r_d.cnt = '0;
        end else if (cycle_end) begin
            case (r_q.st)
                WIN_PRE: begin
                    if (r_q.cnt == CNT_W'(1)) begin
                        r_d.st  = WIN_OPEN;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt - CNT_W'(1);
                    end
                end
                WIN_OPEN: begin
                    r_d.cnt = cnt_inc;
                    if (cnt_inc >= CNT_W'(cap_len)) r_d.st = WIN_DONE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= WIN_IDLE;
            r_q.run_prev <= 1'b0;
            r_q.cnt      <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign is_open = (r_q.st == WIN_OPEN);
endmodule

// File: rtl/pbus_phase_demux.sv
module pbus_phase_demux
    import pbd_pkg::*;
#(
    parameter int AW    = 12,
    parameter int DW    = 8,
    parameter int PRE_W = 16,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tgt_rst_n,
    input  logic             bus_clka,
    input  logic             bus_clkb_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_data,
    input  logic [PRE_W-1:0] pretrig_cycles,
    input  logic [LEN_W-1:0] capture_len,
    output logic             fetch_valid,
    output logic [AW-1:0]    fetch_addr,
    output logic [DW-1:0]    fetch_data,
    output logic             io_valid,
    output logic [AW-1:0]    io_addr,
    output logic [DW-1:0]    io_data,
    output logic             window_open
);
    localparam int SW = AW + DW + 3;
    localparam logic [SW-1:0] SYNC_RST = {3'b001, {(AW + DW){1'b0}}};

    logic [SW-1:0] s_bus;
    logic          s_run, s_a, s_bn;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_data;
    phase_e        ph;
    logic          exit_fetch, exit_acc, lock_lost, win_open;

    pbd_sync #(.W(SW), .RST_VAL(SYNC_RST)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({tgt_rst_n, bus_clka, bus_clkb_n, bus_addr, bus_data}),
        .q     (s_bus)
    );

    assign {s_run, s_a, s_bn, s_addr, s_data} = s_bus;

    pbd_phase_track trk_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_a      (s_a),
        .lvl_b_n    (s_bn),
        .ph_now     (ph),
        .exit_fetch (exit_fetch),
        .exit_acc   (exit_acc),
        .lock_lost  (lock_lost)
    );

    pbd_window #(.PRE_W(PRE_W), .LEN_W(LEN_W)) win_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tgt_run   (s_run),
        .cycle_end (exit_acc),
        .pretrig   (pretrig_cycles),
        .cap_len   (capture_len),
        .is_open   (win_open)
    );

    typedef struct packed {
        logic [AW-1:0] rom_a;     // address held during fetch phase
        logic [DW-1:0] late_d;    // data held during fetch phase
        logic [AW-1:0] acc_a;     // address held during access phase
        logic [DW-1:0] rom_d;     // data held during access phase
        logic [AW-1:0] pend_a;    // access address awaiting its data
        logic          pend_ok;
        logic          fv;
        logic [AW-1:0] fa;
        logic [DW-1:0] fd;
        logic          iv;
        logic [AW-1:0] ia;
        logic [DW-1:0] id;
        logic          wo;
    } rec_t;

    rec_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.fv = 1'b0;
        r_d.iv = 1'b0;
        r_d.wo = win_open;

        if (ph == PH_FETCH) begin
            r_d.rom_a  = s_addr;
            r_d.late_d = s_data;
        end
        if (ph == PH_ACC) begin
            r_d.acc_a = s_addr;
            r_d.rom_d = s_data;
        end

        if (exit_fetch && win_open && r_q.pend_ok) begin
            r_d.iv = 1'b1;
            r_d.ia = r_q.pend_a;
            r_d.id = r_q.late_d;
        end

        if (exit_acc) begin
            r_d.pend_a  = r_q.acc_a;
            r_d.pend_ok = 1'b1;
            if (win_open) begin
                r_d.fv = 1'b1;
                r_d.fa = r_q.rom_a;
                r_d.fd = r_q.rom_d;
            end
        end

        if (lock_lost) r_d.pend_ok = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign fetch_valid = r_q.fv;
    assign fetch_addr  = r_q.fa;
    assign fetch_data  = r_q.fd;
    assign io_valid    = r_q.iv;
    assign io_addr     = r_q.ia;
    assign io_data     = r_q.id;
    assign window_open = r_q.wo;
endmodule

// File: rtl/pbd_checker.sv
module pbd_checker #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tgt_rst_n,
    input logic [LEN_W-1:0] capture_len,
    input logic             fetch_valid,
    input logic             io_valid,
    input logic             window_open
);
    logic [LEN_W:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (fetch_valid) begin
            seen_q <= seen_q + 1'b1;
        end else if (!window_open) begin
            seen_q <= '0;
        end
    end

    AST_FETCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |=> !fetch_valid); // R2

    AST_IO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid |=> !io_valid); // R3

    AST_NO_COINCIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_valid && io_valid)); // R8

    AST_FETCH_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> $past(window_open)); // R8

    AST_IO_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid |-> window_open); // R8

    AST_HELD_RESET_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!tgt_rst_n && !$past(tgt_rst_n) && !$past(tgt_rst_n, 2) && !$past(tgt_rst_n, 3))
        |-> !window_open); // R7

    AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q <= {1'b0, capture_len}); // R6

endmodule

bind pbus_phase_demux pbd_checker #(.LEN_W(LEN_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tgt_rst_n   (tgt_rst_n),
    .capture_len (capture_len),
    .fetch_valid (fetch_valid),
    .io_valid    (io_valid),
    .window_open (window_open)
);

// File: tb/pbus_phase_demux_tb.sv
module pbus_phase_demux_tb_top;
    localparam int PH_LEN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tgt_rst_n = 1'b0;
    logic        bus_clka = 1'b0;
    logic        bus_clkb_n = 1'b1;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic [15:0] pretrig_cycles = '0;
    logic [15:0] capture_len = 16'd1;
    logic        fetch_valid, io_valid, window_open;
    logic [11:0] fetch_addr, io_addr;
    logic [7:0]  fetch_data, io_data;

    always #2 clk = ~clk;

    pbus_phase_demux dut_i (
        .clk(clk), .rst_n(rst_n), .tgt_rst_n(tgt_rst_n),
        .bus_clka(bus_clka), .bus_clkb_n(bus_clkb_n),
        .bus_addr(bus_addr), .bus_data(bus_data),
        .pretrig_cycles(pretrig_cycles), .capture_len(capture_len),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_data(fetch_data),
        .io_valid(io_valid), .io_addr(io_addr), .io_data(io_data),
        .window_open(window_open)
    );

    int checks = 0;
    int fails  = 0;
    int got_f  = 0;
    int got_io = 0;
    bit done   = 0;

    // behavioural reference state
    logic [19:0] exp_f[$];
    logic [19:0] exp_io[$];
    int          m_state = 0; // 0 idle, 1 skipping, 2 open, 3 closed
    int          m_skip = 0;
    int          m_emit = 0;
    int          m_len = 1;
    bit          m_lock = 0;
    bit          m_io_ok = 0;
    logic [11:0] m_io_a = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && fetch_valid) begin
            got_f++;
            if (exp_f.size() == 0) begin
                check(0, "R6", "unexpected fetch record", {12'h0, fetch_addr, fetch_data}, 32'h0);
            end else begin
                logic [19:0] e;
                e = exp_f.pop_front();
                check({fetch_addr, fetch_data} == e, "R2", "fetch record",
                      {12'h0, fetch_addr, fetch_data}, {12'h0, e});
            end
        end
        if (rst_n && io_valid) begin
            got_io++;
            if (exp_io.size() == 0) begin
                check(0, "R4", "unexpected access record", {12'h0, io_addr, io_data}, 32'h0);
            end else begin
                logic [19:0] e;
                e = exp_io.pop_front();
                check({io_addr, io_data} == e, "R3", "access record",
                      {12'h0, io_addr, io_data}, {12'h0, e});
            end
        end
    end

    task automatic drive_ph(input logic a, input logic bn, input logic [11:0] ad,
                            input logic [7:0] dt);
        @(negedge clk);
        bus_clka   = a;
        bus_clkb_n = bn;
        bus_addr   = ad;
        bus_data   = dt;
        repeat (PH_LEN - 1) @(negedge clk);
    endtask

    // R1 level coding: fetch A=1,B=0; clear A=1,B=1; access A=0,B=1; clear A=0,B=0
    task automatic bus_cycle(input logic [11:0] ra, input logic [7:0] rd,
                             input logic [11:0] ia, input logic [7:0] id, input bit glitch);
        drive_ph(1'b1, 1'b1, ra, id);
        if (glitch) begin
            m_lock  = 0;
            m_io_ok = 0;
        end else begin
            if (m_lock && m_state == 2 && m_io_ok) exp_io.push_back({m_io_a, id});
            drive_ph(1'b1, 1'b0, 12'h000, 8'h00);
        end
        drive_ph(1'b0, 1'b0, ia, rd);
        if (m_lock) begin
            m_io_a  = ia;
            m_io_ok = 1;
            if (m_state == 1) begin
                m_skip--;
                if (m_skip == 0) m_state = 2;
            end else if (m_state == 2) begin
                exp_f.push_back({ra, rd});
                m_emit++;
                if (m_emit >= m_len) m_state = 3;
            end
        end
        drive_ph(1'b0, 1'b1, 12'h000, 8'h00);
        m_lock = 1;
    endtask

    task automatic set_tgt(input logic v);
        @(negedge clk);
        tgt_rst_n = v;
        if (!v) begin
            m_state = 0;
        end else begin
            m_skip  = int'(pretrig_cycles);
            m_len   = int'(capture_len);
            m_emit  = 0;
            m_state = (m_skip == 0) ? 2 : 1;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(fetch_valid == 0, "R9", "fetch_valid after reset", 32'(fetch_valid), 0);
        check(io_valid == 0, "R9", "io_valid after reset", 32'(io_valid), 0);
        check(window_open == 0, "R9", "window_open after reset", 32'(window_open), 0);

        // R7: processor held in reset, bus running, nothing reported
        for (int i = 0; i < 3; i++) bus_cycle(12'h050 + 12'(i), 8'h30 + 8'(i), 12'h0C0, 8'h44, 0);
        check(got_f == 0 && got_io == 0, "R7", "records while held in reset", 32'(got_f + got_io), 0);
        check(window_open == 0, "R7", "window while held in reset", 32'(window_open), 0);

        // R5, R6, R1, R2, R3: skip two cycles, then five fetch records
        pretrig_cycles = 16'd2;
        capture_len    = 16'd5;
        set_tgt(1'b1);
        for (int i = 0; i < 9; i++)
            bus_cycle(12'h100 + 12'(i), 8'hA0 + 8'(i), 12'h800 + 12'(3 * i), 8'h10 + 8'(i), 0);
        repeat (8) @(negedge clk);
        check(got_f == 5, "R5", "fetch records after pretrigger skip", 32'(got_f), 5);
        check(got_io == 5, "R3", "access records in window", 32'(got_io), 5);
        check(window_open == 0, "R6", "window after capture length", 32'(window_open), 0);

        // R7 re-arm with no pretrigger; R4 broken phase order
        set_tgt(1'b0);
        check(window_open == 0, "R7", "window after reset asserted", 32'(window_open), 0);
        pretrig_cycles = 16'd0;
        capture_len    = 16'd3;
        set_tgt(1'b1);
        check(window_open == 1, "R7", "window after re-arm with zero skip", 32'(window_open), 1);
        got_f  = 0;
        got_io = 0;
        bus_cycle(12'h200, 8'hC0, 12'h900, 8'h21, 0);
        bus_cycle(12'h201, 8'hC1, 12'h901, 8'h22, 0);
        bus_cycle(12'h2EE, 8'hEE, 12'h9EE, 8'hEE, 1);
        bus_cycle(12'h203, 8'hC3, 12'h903, 8'h24, 0);
        bus_cycle(12'h204, 8'hC4, 12'h904, 8'h25, 0);
        repeat (8) @(negedge clk);
        check(got_f == 3, "R4", "fetch records around broken phase order", 32'(got_f), 3);
        check(got_io == 2, "R4", "access records around broken phase order", 32'(got_io), 2);
        check(exp_f.size() == 0, "R2", "missing fetch records", 32'(exp_f.size()), 0);
        check(exp_io.size() == 0, "R3", "missing access records", 32'(exp_io.size()), 0);
        finish_run();
    end
endmodule